// File: doc/BRIEF.md
# Memory-Operand Instruction Executor

This block carries out the execute phase of the seven memory-operand instructions of a small 16-bit accumulator machine with a 12-bit address space. By the time it starts, the effective address is already resolved. Each cycle it receives that address, a one-hot selection of the instruction, and the value of the external timing sequencer. It owns the accumulator, the carry-extension bit, the program counter, a data register and the address register. It drives one port to a 4096-word by 16-bit memory.

An instruction runs over consecutive timing steps, starting at step 3. The block raises `done` during the final step of the instruction so that the sequencer returns to zero on that clock edge. The address register always drives the memory address. Memory writes take effect on the rising clock edge during a step with `mem_wr` high. Read data must be valid on `mem_rdata` within the same step, while the registered address is held stable.

Top module: `mem_ref_exec`

## Requirements
- R1: While `rst_n` is low, the accumulator, the extension bit and the program counter are zero. `done`, `mem_rd` and `mem_wr` are also low.
- R2: Bit k of `op_hot` selects an instruction: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ. During step 3 the block latches `eff_addr` into the address register. It makes no memory access in step 3, and `done` stays low.
- R3: AND reads the word in step 4. In step 5 it replaces the accumulator with the bitwise AND of the accumulator and that word. The extension bit is unchanged, and `done` is high in step 5.
- R4: ADD reads the word in step 4. In step 5 the accumulator takes the low 16 bits of the sum of the accumulator and the word, and the extension bit takes the carry. `done` is high in step 5.
- R5: LDA reads the word in step 4 and copies it to the accumulator in step 5, with `done` high in step 5.
- R6: STA writes the accumulator to the effective address in step 4, with `done` high in step 4. The accumulator is unchanged.
- R7: BUN loads the effective address into the program counter in step 4, with `done` high in step 4.
- R8: BSA writes the program counter, zero-extended to 16 bits, to the effective address in step 4. In step 5 it loads the effective address plus one into the program counter, wrapping modulo 4096. `done` is high in step 5.
- R9: ISZ reads the word in step 4 and increments it in step 5. In step 6 it writes the incremented word back. If the new value is zero, the program counter advances by one in the same step. `done` is high in step 6.
- R10: `mem_rd` is high only in step 4 of AND, ADD, LDA and ISZ. `mem_wr` is high only in step 4 of STA and BSA and in step 6 of ISZ. `done` is high in exactly one step per instruction.
- R11: An instruction leaves unchanged every register and memory word that its requirement does not name.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_hot | input | 7 | One-hot instruction select |
| step | input | 4 | Current timing step from the sequencer |
| eff_addr | input | 12 | Resolved effective address |
| mem_addr | output | 12 | Memory address, from the address register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe, committed on the clock edge |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data for the current address |
| done | output | 1 | Final step of the instruction; clears the sequencer |
| acc_q | output | 16 | Accumulator |
| e_q | output | 1 | Carry-extension bit |
| pc_q | output | 12 | Program counter |

## Verification
A wrong address register shows up at the ports at step 4, as a read or a write to the wrong memory word. A wrong data register stays hidden until step 5 or step 6, when it reaches the accumulator or memory, or causes a skip where none was due. A bad carry or a missed skip can stay latent for several instructions until a later ADD, store or branch exposes it. For that reason the bench compares the accumulator, extension bit, program counter and target memory word against a model after every instruction, and checks each strobe at every step.

// File: rtl/mr_pkg.sv
package mr_pkg;
  // instruction select bit positions
  localparam int unsigned OP_AND   = 0;
  localparam int unsigned OP_ADD   = 1;
  localparam int unsigned OP_LDA   = 2;
  localparam int unsigned OP_STA   = 3;
  localparam int unsigned OP_BUN   = 4;
  localparam int unsigned OP_BSA   = 5;
  localparam int unsigned OP_ISZ   = 6;
  localparam int unsigned OP_COUNT = 7;

  // timing steps used by the execute phase
  localparam int unsigned ST_ADDR = 3;
  localparam int unsigned ST_MEM  = 4;
  localparam int unsigned ST_OPER = 5;
  localparam int unsigned ST_LAST = 6;

  typedef struct packed {
    logic ar_take;
    logic ar_bump;
    logic dr_fetch;
    logic dr_bump;
    logic ac_and;
    logic ac_add;
    logic ac_load;
    logic pc_from_ar;
    logic pc_skip;
    logic wr_acc;
    logic wr_pc;
    logic wr_dr;
    logic rd;
    logic done;
  } mr_ctl_t;
endpackage

// File: rtl/mr_step_decode.sv
module mr_step_decode
  import mr_pkg::*;
#(
  parameter int unsigned STEP_W = 4,
  parameter int unsigned OPS    = OP_COUNT
) (
  input  logic [OPS-1:0]    op_hot,
  input  logic [STEP_W-1:0] step,
  output mr_ctl_t           ctl
);
  logic s_addr, s_mem, s_oper, s_last;
  logic any_op, reads_mem;

  assign s_addr    = (step == STEP_W'(ST_ADDR));
  assign s_mem     = (step == STEP_W'(ST_MEM));
  assign s_oper    = (step == STEP_W'(ST_OPER));
  assign s_last    = (step == STEP_W'(ST_LAST));
  assign any_op    = |op_hot;
  assign reads_mem = op_hot[OP_AND] | op_hot[OP_ADD] | op_hot[OP_LDA] | op_hot[OP_ISZ];

  always_comb begin
    ctl            = '0;
    ctl.ar_take    = s_addr & any_op;
    ctl.dr_fetch   = s_mem & reads_mem;
    ctl.rd         = s_mem & reads_mem;
    ctl.ac_and     = s_oper & op_hot[OP_AND];
    ctl.ac_add     = s_oper & op_hot[OP_ADD];
    ctl.ac_load    = s_oper & op_hot[OP_LDA];
    ctl.wr_acc     = s_mem & op_hot[OP_STA];
    ctl.wr_pc      = s_mem & op_hot[OP_BSA];
    ctl.ar_bump    = s_mem & op_hot[OP_BSA];
    ctl.pc_from_ar = (s_mem & op_hot[OP_BUN]) | (s_oper & op_hot[OP_BSA]);
    ctl.dr_bump    = s_oper & op_hot[OP_ISZ];
    ctl.wr_dr      = s_last & op_hot[OP_ISZ];
    ctl.pc_skip    = s_last & op_hot[OP_ISZ];
    ctl.done       = (s_mem  & (op_hot[OP_STA] | op_hot[OP_BUN]))
                   | (s_oper & (op_hot[OP_AND] | op_hot[OP_ADD] | op_hot[OP_LDA] | op_hot[OP_BSA]))
                   | (s_last & op_hot[OP_ISZ]);
  end
endmodule

// File: rtl/mr_datapath.sv
module mr_datapath
  import mr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mr_ctl_t           ctl,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ac,
  output logic              e,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] wdata
);
  localparam int unsigned PAD_W = DATA_W - ADDR_W;

  function automatic logic [DATA_W:0] add_carry(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DATA_W-1:0] word_inc(input logic [DATA_W-1:0] w);
    return w + DATA_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [DATA_W:0] sum;
  logic            unused_ctl;

  assign sum        = add_carry(ac, dr);
  assign unused_ctl = ^{ctl.rd, ctl.done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar <= '0;
      dr <= '0;
      ac <= '0;
      e  <= 1'b0;
      pc <= '0;
    end else begin
      if (ctl.ar_take)      ar <= eff_addr;
      else if (ctl.ar_bump) ar <= addr_inc(ar);

      if (ctl.dr_fetch)     dr <= mem_rdata;
      else if (ctl.dr_bump) dr <= word_inc(dr);

      if (ctl.ac_and)       ac <= ac & dr;
      else if (ctl.ac_add)  {e, ac} <= sum;
      else if (ctl.ac_load) ac <= dr;

      if (ctl.pc_from_ar)                   pc <= ar;
      else if (ctl.pc_skip && (dr == '0))   pc <= addr_inc(pc);
    end
  end

  always_comb begin
    if (ctl.wr_acc)     wdata = ac;
    else if (ctl.wr_pc) wdata = {{PAD_W{1'b0}}, pc};
    else                wdata = dr;
  end
endmodule

// File: rtl/mem_ref_exec.sv
module mem_ref_exec
  import mr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned STEP_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_COUNT-1:0] op_hot,
  input  logic [STEP_W-1:0]   step,
  input  logic [ADDR_W-1:0]   eff_addr,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                done,
  output logic [DATA_W-1:0]   acc_q,
  output logic                e_q,
  output logic [ADDR_W-1:0]   pc_q
);
  mr_ctl_t           ctl;
  logic [ADDR_W-1:0] ar_w;
  logic [DATA_W-1:0] dr_w;

  mr_step_decode #(.STEP_W(STEP_W), .OPS(OP_COUNT)) u_dec (
    .op_hot (op_hot),
    .step   (step),
    .ctl    (ctl)
  );

  mr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .eff_addr  (eff_addr),
    .mem_rdata (mem_rdata),
    .ac        (acc_q),
    .e         (e_q),
    .pc        (pc_q),
    .ar        (ar_w),
    .dr        (dr_w),
    .wdata     (mem_wdata)
  );

  assign mem_addr = ar_w;
  assign mem_rd   = ctl.rd;
  assign mem_wr   = ctl.wr_acc | ctl.wr_pc | ctl.wr_dr;
  assign done     = ctl.done;
endmodule

// File: rtl/mem_ref_exec_chk.sv
module mem_ref_exec_chk
  import mr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned STEP_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [OP_COUNT-1:0] op_hot,
  input logic [STEP_W-1:0]   step,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                done,
  input logic [DATA_W-1:0]   acc_q,
  input logic                e_q,
  input logic [ADDR_W-1:0]   pc_q,
  input logic [DATA_W-1:0]   dr_q
);
  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (step > STEP_W'(ST_ADDR)));

  // R2
  addr_step_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(ST_ADDR)) |=> (acc_q == $past(acc_q)) && (pc_q == $past(pc_q)));

  // R4
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(ST_OPER) && op_hot[OP_ADD]) |=>
      ({e_q, acc_q} == ({1'b0, $past(dr_q)} + {1'b0, $past(acc_q)})));

  // R5
  load_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(ST_OPER) && op_hot[OP_LDA]) |=> (acc_q == $past(dr_q)));

  // R6
  store_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(ST_MEM) && op_hot[OP_STA]) |-> (mem_wr && done && mem_wdata == acc_q));

  // R7
  branch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(ST_MEM) && op_hot[OP_BUN]) |=> (pc_q == $past(mem_addr)));

  // R9
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(ST_LAST) && op_hot[OP_ISZ] && mem_wdata == '0) |=>
      (pc_q == $past(pc_q) + ADDR_W'(1)));
endmodule

bind mem_ref_exec mem_ref_exec_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_hot    (op_hot),
  .step      (step),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .acc_q     (acc_q),
  .e_q       (e_q),
  .pc_q      (pc_q),
  .dr_q      (dr_w)
);

// File: tb/test_mem_ref_exec.sv
`timescale 1ns/1ps
module test_mem_ref_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  op_hot;
  logic [3:0]  step;
  logic [11:0] eff_addr;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, done, e_q;
  logic [15:0] mem_wdata, mem_rdata, acc_q;
  logic [11:0] pc_q;

  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [15:0] exp_ac;
  logic        exp_e;
  logic [11:0] exp_pc;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mem_ref_exec i_mem_ref_exec (
    .clk(clk), .rst_n(rst_n), .op_hot(op_hot), .step(step), .eff_addr(eff_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .acc_q(acc_q), .e_q(e_q), .pc_q(pc_q)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int last_step(input int k);
    if (k == 3 || k == 4) return 4;
    if (k == 6) return 6;
    return 5;
  endfunction

  function automatic string ac_tag(input int k);
    case (k)
      0: return "R3 acc";
      1: return "R4 acc";
      2: return "R5 acc";
      default: return "R11 acc";
    endcase
  endfunction

  task automatic poke(input logic [11:0] a, input logic [15:0] v);
    mem[a[7:0]] = v;
    exp_mem[a[7:0]] = v;
  endtask

  task automatic exec(input int k, input logic [11:0] a);
    logic [15:0] w;
    logic [16:0] s;
    int fin;
    bit saw;
    fin = last_step(k);
    saw = 0;
    @(negedge clk);
    op_hot = 7'(1 << k);
    eff_addr = a;
    for (int st = 3; st <= 7 && !saw; st++) begin
      step = 4'(st);
      #1;
      chk("R10 rd strobe", 32'(mem_rd), 32'((st == 4) && (k == 0 || k == 1 || k == 2 || k == 6)));
      chk("R10 wr strobe", 32'(mem_wr), 32'(((st == 4) && (k == 3 || k == 5)) || ((st == 6) && (k == 6))));
      chk("R10 done step", 32'(done), 32'(st == fin));
      if (done) saw = 1;
      @(negedge clk);
    end
    op_hot = '0;
    step = '0;
    // reference model
    w = exp_mem[a[7:0]];
    case (k)
      0: exp_ac = exp_ac & w;
      1: begin s = 17'(exp_ac) + 17'(w); exp_ac = s[15:0]; exp_e = s[16]; end
      2: exp_ac = w;
      3: exp_mem[a[7:0]] = exp_ac;
      4: exp_pc = a;
      5: begin exp_mem[a[7:0]] = {4'h0, exp_pc}; exp_pc = a + 12'd1; end
      default: begin w = w + 16'd1; exp_mem[a[7:0]] = w; if (w == 16'h0) exp_pc = exp_pc + 12'd1; end
    endcase
    #1;
    chk(ac_tag(k), 32'(acc_q), 32'(exp_ac));
    chk((k == 1) ? "R4 carry" : "R11 carry", 32'(e_q), 32'(exp_e));
    chk((k == 4) ? "R7 pc" : (k == 5) ? "R8 pc" : (k == 6) ? "R9 pc" : "R11 pc", 32'(pc_q), 32'(exp_pc));
    chk((k == 3) ? "R6 mem" : (k == 5) ? "R8 mem" : (k == 6) ? "R9 mem" : "R11 mem",
        32'(mem[a[7:0]]), 32'(exp_mem[a[7:0]]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; op_hot = '0; step = '0; eff_addr = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'($urandom);
      exp_mem[i] = mem[i];
    end
    exp_ac = '0; exp_e = 1'b0; exp_pc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 acc", 32'(acc_q), 0);
    chk("R1 carry", 32'(e_q), 0);
    chk("R1 pc", 32'(pc_q), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 strobes", 32'({mem_rd, mem_wr}), 0);
    rst_n = 1'b1;

    // R4 carry out of all-ones plus one
    poke(12'h010, 16'hFFFF); exec(2, 12'h010);
    poke(12'h011, 16'h0001); exec(1, 12'h011);
    // R9 skip and no skip
    poke(12'h020, 16'hFFFF); exec(6, 12'h020);
    poke(12'h021, 16'h0005); exec(6, 12'h021);
    // R7 / R8 branch, call with address wrap
    exec(4, 12'h123);
    exec(5, 12'hFFF);
    exec(5, 12'h0A5);
    // R3 AND with zero, R6 store
    poke(12'h030, 16'h0000); exec(0, 12'h030);
    exec(3, 12'h031);

    for (int i = 0; i < 400; i++)
      exec(int'($urandom % 7), 12'($urandom));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule